// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital side of a 10-bit successive-approximation converter. It waits for a start event, then drives a trial code to an external DAC and refines that code one bit per clock. Each refinement uses a single comparator bit that reports whether the sampled input is at or above the trial code. When the last bit is decided, the block stores the code as the result and emits a one-clock completion pulse.

A 3-bit selector picks one of six start events: a software strobe, one of four timer overflow pulses, or a rising edge on an external start pin. That pin is asynchronous, so it passes through two flops before its edge is detected. When a result completes, the block compares it against a lower and an upper limit. A result outside the band between them raises a sticky window flag, which software clears.

While the enable input is low the sequencer stays in shutdown. Clearing enable during a conversion abandons that conversion.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy, done, win_flag, result and dac_code are all 0.
- R2: With enable high and busy low, the start event chosen by start_sel starts a conversion on that clock edge. The codes are 000 = sw_start, 001 = tmr0_ovf, 010 = tmr2_ovf, 011 = tmr1_ovf, 100 = rising edge of ext_cnv, 101 = tmr3_ovf. Events on sources that are not selected have no effect.
- R3: start_sel codes 110 and 111 never start a conversion.
- R4: While enable is low no conversion starts. If enable is low at a clock edge during a conversion, busy is 0 after that edge and no done pulse follows.
- R5: busy is high for exactly 11 cycles from the start edge: one load cycle and then ten bit-decision cycles. done is high for one cycle, starting on the edge where busy falls.
- R6: In the cycle after the start edge, dac_code is 10'b1000000000. Each decision keeps the bit under trial when cmp_hi is 1, clears it when cmp_hi is 0, and sets the next lower bit. As a result, a comparator that reports input >= dac_code yields result equal to the input code.
- R7: A start event that arrives while busy is high is ignored. This includes an event on the edge that ends a conversion.
- R8: ext_cnv passes through two synchronizer flops. A rising edge on it starts a conversion on the third clock edge after the rise. Holding the pin high does not start another conversion.
- R9: On the edge that raises done, win_flag is set if result < lt_thr or result > gt_thr. A result equal to either limit does not set it.
- R10: win_flag stays set until win_clr is high at a clock edge. If a set and a clear fall on the same edge, the set wins.
- R11: result changes only on the edge that raises done and holds its value between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 means shutdown |
| start_sel | input | 3 | Start source select |
| sw_start | input | 1 | Software start strobe |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| ext_cnv | input | 1 | Asynchronous external start pin |
| cmp_hi | input | 1 | Comparator: input >= dac_code |
| gt_thr | input | 10 | Upper window limit |
| lt_thr | input | 10 | Lower window limit |
| win_clr | input | 1 | Clears the window flag |
| dac_code | output | 10 | Trial code to the DAC |
| result | output | 10 | Last completed conversion |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| win_flag | output | 1 | Sticky out-of-window flag |

## Verification
Two collisions can happen on the edge that completes a conversion. The window-flag set can meet a software clear, and a new start event can meet the falling busy. The bench raises win_clr on the final decision edge of a conversion whose input lies outside the window, and expects the flag to remain set. It also pulses sw_start on that same edge and expects busy to stay low afterwards. Both checks rest on a bench model in which a comparator is computed from an input value, and on a sticky flag tracked by the bench.

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [2:0]   start_sel,
  input  logic         sw_start,
  input  logic         tmr0_ovf,
  input  logic         tmr1_ovf,
  input  logic         tmr2_ovf,
  input  logic         tmr3_ovf,
  input  logic         ext_cnv,
  input  logic         cmp_hi,
  input  logic [W-1:0] gt_thr,
  input  logic [W-1:0] lt_thr,
  input  logic         win_clr,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] result,
  output logic         busy,
  output logic         done,
  output logic         win_flag
);
  localparam int IW = $clog2(W);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  logic         sync1, sync2, ext_prev;
  logic         loading;
  logic [IW-1:0] idx;
  logic [W-1:0] trial, nxt;
  logic         trig, last, win_hit;

  wire ext_rise = sync2 & ~ext_prev;

  always_comb begin
    case (start_sel)
      3'b000:  trig = sw_start;
      3'b001:  trig = tmr0_ovf;
      3'b010:  trig = tmr2_ovf;
      3'b011:  trig = tmr1_ovf;
      3'b100:  trig = ext_rise;
      3'b101:  trig = tmr3_ovf;
      default: trig = 1'b0;
    endcase
  end

  always_comb begin
    nxt = trial;
    if (!cmp_hi) nxt[idx] = 1'b0;
    if (idx != '0) nxt[idx - 1'b1] = 1'b1;
  end

  assign last    = enable && busy && !loading && (idx == '0);
  assign win_hit = last && ((nxt < lt_thr) || (nxt > gt_thr));
  assign dac_code = trial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      ext_prev <= 1'b0;
    end else begin
      sync1    <= ext_cnv;
      sync2    <= sync1;
      ext_prev <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      loading <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      trial   <= '0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        busy    <= 1'b0;
        loading <= 1'b0;
      end else if (!busy) begin
        if (trig) begin
          busy    <= 1'b1;
          loading <= 1'b1;
          trial   <= '0;
        end
      end else if (loading) begin
        loading <= 1'b0;
        trial   <= TOP;
        idx     <= IW'(W - 1);
      end else begin
        trial <= nxt;
        if (idx == '0) begin
          result <= nxt;
          done   <= 1'b1;
          busy   <= 1'b0;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       win_flag <= 1'b0;
    else if (win_hit) win_flag <= 1'b1;
    else if (win_clr) win_flag <= 1'b0;
  end
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic [2:0]   start_sel,
  input logic         win_clr,
  input logic [W-1:0] dac_code,
  input logic [W-1:0] result,
  input logic         busy,
  input logic         done,
  input logic         win_flag
);
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy && !done);
  a_r3_reserved_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_sel[2:1] == 2'b11) |=> !busy);
  a_r6_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && enable) |=> (dac_code == {1'b1, {(W-1){1'b0}}}) || !busy);
  a_r9_set_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_flag) |-> done);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (win_flag && !win_clr) |=> win_flag);
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .start_sel(start_sel),
  .win_clr(win_clr), .dac_code(dac_code), .result(result),
  .busy(busy), .done(done), .win_flag(win_flag)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [2:0] start_sel = '0;
  logic sw_start = 0, tmr0_ovf = 0, tmr1_ovf = 0, tmr2_ovf = 0, tmr3_ovf = 0, ext_cnv = 0;
  logic [9:0] gt_thr = 10'd1023, lt_thr = 10'd0;
  logic win_clr = 0;
  logic [9:0] dac_code, result;
  logic busy, done, win_flag;
  logic [9:0] vin = '0;
  logic cmp_hi;
  int checks = 0, errors = 0;
  bit exp_win = 0;

  assign cmp_hi = (vin >= dac_code);

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_sel(start_sel),
    .sw_start(sw_start), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf), .ext_cnv(ext_cnv),
    .cmp_hi(cmp_hi), .gt_thr(gt_thr), .lt_thr(lt_thr), .win_clr(win_clr),
    .dac_code(dac_code), .result(result), .busy(busy), .done(done),
    .win_flag(win_flag)
  );

  function automatic bit outside(input logic [9:0] r, input logic [9:0] lo, input logic [9:0] hi);
    return (r < lo) || (r > hi);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_src(input int src, input logic v);
    case (src)
      0: sw_start = v;
      1: tmr0_ovf = v;
      2: tmr2_ovf = v;
      3: tmr1_ovf = v;
      5: tmr3_ovf = v;
      default: ;
    endcase
  endtask

  task automatic clear_flag();
    @(negedge clk); win_clr = 1;
    @(negedge clk); win_clr = 0;
    exp_win = 0;
    check(win_flag == 0, "R10 clear", win_flag, 0);
  endtask

  // full conversion; collide=1 raises win_clr and sw_start on the final edge
  task automatic convert(input int sel, input logic [9:0] v, input bit collide);
    @(negedge clk);
    start_sel = 3'(sel); vin = v;
    if (sel == 4) begin
      ext_cnv = 1;
      @(negedge clk); check(busy == 0, "R8 sync stage 1", busy, 0);
      @(negedge clk); check(busy == 0, "R8 sync stage 2", busy, 0);
      @(negedge clk); check(busy == 1, "R8 start on third edge", busy, 1);
    end else begin
      drive_src(sel, 1);
      @(negedge clk); drive_src(sel, 0);
      check(busy == 1, "R2 selected source starts", busy, 1);
    end
    @(negedge clk);
    check(dac_code == 10'h200, "R6 first trial code", dac_code, 10'h200);
    for (int k = 0; k < 9; k++) begin
      check(busy == 1 && done == 0, "R5 busy during conversion", {busy, done}, 2);
      if (k == 4) sw_start = 1;
      if (k == 5) sw_start = 0;
      @(negedge clk);
    end
    check(busy == 1, "R5 busy last decision", busy, 1);
    if (collide) begin win_clr = 1; if (start_sel == 0) sw_start = 1; end
    @(negedge clk);
    win_clr = 0; sw_start = 0;
    if (outside(v, lt_thr, gt_thr)) exp_win = 1;
    else if (collide) exp_win = 0;
    check(done == 1 && busy == 0, "R5 done with busy fall", {busy, done}, 1);
    check(result == v, "R6 result equals input", result, v);
    check(win_flag == exp_win, "R9 window flag", win_flag, exp_win);
    @(negedge clk);
    check(done == 0, "R5 done one cycle", done, 0);
    check(busy == 0, "R7 no retrigger while busy", busy, 0);
    if (sel == 4) begin
      repeat (4) @(negedge clk);
      check(busy == 0, "R8 held pin no restart", busy, 0);
      ext_cnv = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] keep;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && win_flag == 0, "R1 reset flags", {busy, done, win_flag}, 0);
    check(result == 0 && dac_code == 0, "R1 reset data", result, 0);
    rst_n = 1;
    // R4 disabled: triggers ignored
    @(negedge clk); start_sel = 0; sw_start = 1;
    @(negedge clk); sw_start = 0;
    check(busy == 0, "R4 disabled ignores start", busy, 0);
    enable = 1;
    // R3 reserved codes
    for (int s = 6; s < 8; s++) begin
      @(negedge clk); start_sel = 3'(s);
      sw_start = 1; tmr0_ovf = 1; tmr1_ovf = 1; tmr2_ovf = 1; tmr3_ovf = 1; ext_cnv = 1;
      repeat (5) @(negedge clk);
      sw_start = 0; tmr0_ovf = 0; tmr1_ovf = 0; tmr2_ovf = 0; tmr3_ovf = 0; ext_cnv = 0;
      check(busy == 0, "R3 reserved select", busy, 0);
      repeat (3) @(negedge clk);
    end
    // R2 unselected source ignored
    @(negedge clk); start_sel = 3'b001; tmr2_ovf = 1; sw_start = 1; tmr3_ovf = 1;
    @(negedge clk); tmr2_ovf = 0; sw_start = 0; tmr3_ovf = 0;
    check(busy == 0, "R2 unselected source ignored", busy, 0);
    // directed boundaries
    lt_thr = 10'd100; gt_thr = 10'd900;
    convert(0, 10'd0, 0);
    clear_flag();
    convert(1, 10'd1023, 0);
    clear_flag();
    convert(2, 10'd100, 0);
    convert(3, 10'd900, 0);
    convert(5, 10'd99, 0);
    clear_flag();
    convert(4, 10'd901, 0);
    // R10 collision: set wins over clear, sw_start on end edge ignored
    convert(0, 10'd5, 1);
    convert(0, 10'd500, 1);
    // R11 result hold
    keep = result; vin = 10'd77;
    repeat (5) @(negedge clk);
    check(result == keep, "R11 result holds", result, keep);
    // R4 abort mid conversion
    @(negedge clk); start_sel = 0; sw_start = 1;
    @(negedge clk); sw_start = 0;
    repeat (4) @(negedge clk);
    enable = 0;
    @(negedge clk);
    check(busy == 0, "R4 abort drops busy", busy, 0);
    enable = 1;
    repeat (12) begin
      @(negedge clk);
      check(done == 0, "R4 no done after abort", done, 0);
    end
    check(result == keep, "R11 result after abort", result, keep);
    // random
    for (int n = 0; n < 40; n++) begin
      int sel;
      logic [9:0] a, b;
      sel = int'($urandom_range(0, 5));
      a = 10'($urandom); b = 10'($urandom);
      lt_thr = (a < b) ? a : b; gt_thr = (a < b) ? b : a;
      clear_flag();
      convert(sel, 10'($urandom), n % 7 == 3);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule